// File: doc/BRIEF.md
# Multiplexed Segment LCD Drive Sequencer

This block scans a segment LCD panel with up to four common lines and twenty-two segment lines. It runs from a 32.768 kHz clock. A static duty input selects two, three or four active commons. The block steps through one common time slot after another. For every COM and SEG terminal it outputs a 2-bit code that names one of four drive potentials. Analog circuitry outside the block turns each code into a voltage.

Segment data comes from a 32-nibble display memory. This memory can only be written and has no read path. Two control bits shape the output:
- The power-enable bit forces every terminal to the middle potential.
- The display-off bit blanks every segment while the commons keep scanning.

A per-segment static mask turns chosen SEG pins into plain DC outputs. These pins follow one memory bit and ignore both control bits.

The scan is built on a four-state machine with states ST_COM0, ST_COM1, ST_COM2 and ST_COM3, one state per active common. Every state waits for the end of its 256-cycle slot. At that point it takes one of these transitions:
- ST_COM0 always goes to ST_COM1.
- ST_COM1 goes back to ST_COM0 at two-common duty, and to ST_COM2 otherwise.
- ST_COM2 goes back to ST_COM0 at three-common duty, and to ST_COM3 otherwise.
- ST_COM3 always goes back to ST_COM0.

A separate frame counter sets the drive polarity. The polarity inverts every half frame.

Top module: `lcd_mux_drive`

## Requirements
- R1: Exactly one common is selected at a time. Each selection lasts 256 clocks. The scan order is COM0, COM1, COM2, COM3, and it wraps to COM0 after the last common in use. Scanning starts at COM0 with positive polarity on the first cycle after reset.
- R2: duty_sel encodes the number of commons:
  - 0 selects 2 commons (COM0 and COM1).
  - 1 selects 3 commons (COM0 to COM2).
  - 2 and 3 both select 4 commons.
  A common outside the chosen count is never selected. While powered, it always shows the unselected level.
- R3: The frame is 768 clocks when duty_sel is 1 and 1024 clocks otherwise. Polarity is positive in the first half of each frame and negative in the second half.
- R4: Level codes are 0 for VSS, 1 for VC1, 2 for VC2 and 3 for VC3. At positive polarity:
  - the selected common drives VC3;
  - unselected commons drive VC1;
  - a lit segment drives VSS;
  - an unlit segment drives VC2.
  At negative polarity:
  - the selected common drives VSS;
  - unselected commons drive VC2;
  - a lit segment drives VC3;
  - an unlit segment drives VC1.
- R5: While COMk is selected, segment n is lit exactly when bit k of display nibble n is 1. A write (mem_we with mem_addr and mem_wdata) takes effect at the next clock edge.
- R6: The power-enable bit resets to 0. While it is 0, every common and every non-static segment outputs code 2 (VC2).
- R7: The display-off bit resets to 0. While it is 1 and power is enabled, every non-static segment shows the unlit level for the current polarity, and the commons continue to scan. ctl_we loads both control bits at the clock edge.
- R8: A segment n whose static_mask bit is 1 outputs code 3 if bit 0 of nibble n is 1 and code 0 otherwise, whatever the power and display-off bits are.
- R9: Writes to nibble addresses 22 to 31 change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz scan clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| duty_sel | input | 2 | Static duty code (0: 2 commons, 1: 3 commons, 2/3: 4 commons) |
| static_mask | input | 22 | Per-segment static DC output enable |
| mem_we | input | 1 | Display memory write strobe |
| mem_addr | input | 5 | Display memory nibble address |
| mem_wdata | input | 4 | Display memory write data |
| ctl_we | input | 1 | Control register write strobe |
| ctl_pwr_on | input | 1 | Power-enable value loaded on ctl_we |
| ctl_disp_off | input | 1 | Display-off value loaded on ctl_we |
| com_lvl | output | 8 | Two-bit level code per common, COMk at bits 2k+1:2k |
| seg_lvl | output | 44 | Two-bit level code per segment, SEGn at bits 2n+1:2n |

## Verification
The checker assumes the following about the inputs:
- duty_sel and static_mask are static between resets.
- The scan counters start together at reset release.
- The power-enable bit stays valid across a slot boundary whenever a change of selected common is judged.

The stimulus respects these assumptions. It changes duty_sel and static_mask only while rst_n is low, and it starts a fresh reset for each of the four duty codes. The control register is written only through single-cycle ctl_we pulses, so power and display-off settle at clock edges, exactly as the behavioural model in the bench expects.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;

    localparam int N_COM = 4;

    typedef enum logic [1:0] {
        LVL_VSS = 2'd0,
        LVL_VC1 = 2'd1,
        LVL_VC2 = 2'd2,
        LVL_VC3 = 2'd3
    } lvl_t;

    typedef enum logic [1:0] {
        DUTY_HALF    = 2'd0,
        DUTY_THIRD   = 2'd1,
        DUTY_QUARTER = 2'd2,
        DUTY_ALT4    = 2'd3
    } duty_t;

    typedef enum logic [1:0] {
        ST_COM0 = 2'd0,
        ST_COM1 = 2'd1,
        ST_COM2 = 2'd2,
        ST_COM3 = 2'd3
    } scan_state_t;

    function automatic logic [2:0] commons_used(input logic [1:0] duty);
        case (duty)
            DUTY_HALF:  return 3'd2;
            DUTY_THIRD: return 3'd3;
            default:    return 3'd4;
        endcase
    endfunction

    function automatic lvl_t com_drive(input logic sel, input logic neg);
        if (sel) return neg ? LVL_VSS : LVL_VC3;
        else     return neg ? LVL_VC2 : LVL_VC1;
    endfunction

    function automatic lvl_t seg_drive(input logic lit, input logic neg);
        if (lit) return neg ? LVL_VC3 : LVL_VSS;
        else     return neg ? LVL_VC1 : LVL_VC2;
    endfunction

endpackage

// File: rtl/lcd_scan_fsm.sv
module lcd_scan_fsm
    import lcd_drv_pkg::*;
#(
    parameter int SLOT_CYCLES = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       duty,
    output logic [N_COM-1:0] slot_sel,
    output logic             neg_pol
);

    localparam int SW = $clog2(SLOT_CYCLES);
    localparam int FW = $clog2(N_COM * SLOT_CYCLES);
    localparam logic [SW-1:0] SLOT_LAST   = SW'(SLOT_CYCLES - 1);
    localparam logic [FW-1:0] FRAME_LONG  = FW'(N_COM * SLOT_CYCLES - 1);
    localparam logic [FW-1:0] FRAME_SHORT = FW'((N_COM - 1) * SLOT_CYCLES - 1);

    scan_state_t     state, state_nx;
    logic [SW-1:0]   slot_cnt;
    logic [FW-1:0]   frame_cnt;
    logic [FW-1:0]   frame_last;
    logic [FW:0]     half_len;
    logic            slot_end;
    logic [2:0]      ncom;

    assign ncom       = commons_used(duty);
    assign slot_end   = (slot_cnt == SLOT_LAST);
    assign frame_last = (duty == DUTY_THIRD) ? FRAME_SHORT : FRAME_LONG;
    assign half_len   = ({1'b0, frame_last} + 1'b1) >> 1;
    assign neg_pol    = ({1'b0, frame_cnt} >= half_len);

    // slot and frame timebase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_cnt  <= '0;
            frame_cnt <= '0;
        end else begin
            slot_cnt  <= slot_end ? '0 : slot_cnt + 1'b1;
            frame_cnt <= (frame_cnt == frame_last) ? '0 : frame_cnt + 1'b1;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_COM0;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        if (slot_end) begin
            unique case (state)
                ST_COM0: state_nx = ST_COM1;
                ST_COM1: state_nx = (ncom == 3'd2) ? ST_COM0 : ST_COM2;
                ST_COM2: state_nx = (ncom == 3'd3) ? ST_COM0 : ST_COM3;
                ST_COM3: state_nx = ST_COM0;
            endcase
        end
    end

    // outputs
    always_comb begin
        slot_sel = '0;
        unique case (state)
            ST_COM0: slot_sel[0] = 1'b1;
            ST_COM1: slot_sel[1] = 1'b1;
            ST_COM2: slot_sel[2] = 1'b1;
            ST_COM3: slot_sel[3] = 1'b1;
        endcase
    end

endmodule

// File: rtl/lcd_disp_mem.sv
module lcd_disp_mem #(
    parameter int DEPTH = 32,
    parameter int N_SEG = 22,
    parameter int NW    = 4,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [AW-1:0]            addr,
    input  logic [NW-1:0]            wdata,
    output logic [N_SEG-1:0][NW-1:0] nib
);

    logic [DEPTH-1:0][NW-1:0] cells;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cells <= '0;
        end else if (we) begin
            cells[addr] <= wdata;
        end
    end

    for (genvar n = 0; n < N_SEG; n++) begin : g_tap
        assign nib[n] = cells[n];
    end

endmodule

// File: rtl/lcd_level_map.sv
module lcd_level_map
    import lcd_drv_pkg::*;
#(
    parameter int N_SEG = 22
) (
    input  logic [N_COM-1:0]            slot_sel,
    input  logic                        neg_pol,
    input  logic                        pwr_on,
    input  logic                        disp_off,
    input  logic [N_SEG-1:0]            static_mask,
    input  logic [N_SEG-1:0][N_COM-1:0] nib,
    output logic [2*N_COM-1:0]          com_lvl,
    output logic [2*N_SEG-1:0]          seg_lvl
);

    for (genvar k = 0; k < N_COM; k++) begin : g_com
        assign com_lvl[2*k +: 2] = pwr_on ? com_drive(slot_sel[k], neg_pol) : LVL_VC2;
    end

    for (genvar n = 0; n < N_SEG; n++) begin : g_seg
        logic lit;
        assign lit = |(nib[n] & slot_sel) & ~disp_off;
        always_comb begin
            if (static_mask[n])
                seg_lvl[2*n +: 2] = nib[n][0] ? LVL_VC3 : LVL_VSS;
            else if (!pwr_on)
                seg_lvl[2*n +: 2] = LVL_VC2;
            else
                seg_lvl[2*n +: 2] = seg_drive(lit, neg_pol);
        end
    end

endmodule

// File: rtl/lcd_mux_drive.sv
module lcd_mux_drive
    import lcd_drv_pkg::*;
#(
    parameter int SLOT_CYCLES = 256,
    parameter int N_SEG       = 22,
    parameter int MEM_DEPTH   = 32,
    localparam int AW         = $clog2(MEM_DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         duty_sel,
    input  logic [N_SEG-1:0]   static_mask,
    input  logic               mem_we,
    input  logic [AW-1:0]      mem_addr,
    input  logic [N_COM-1:0]   mem_wdata,
    input  logic               ctl_we,
    input  logic               ctl_pwr_on,
    input  logic               ctl_disp_off,
    output logic [2*N_COM-1:0] com_lvl,
    output logic [2*N_SEG-1:0] seg_lvl
);

    logic                        pwr_q;
    logic                        off_q;
    logic [N_COM-1:0]            slot_sel;
    logic                        neg_pol;
    logic [N_SEG-1:0][N_COM-1:0] nib;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwr_q <= 1'b0;
            off_q <= 1'b0;
        end else if (ctl_we) begin
            pwr_q <= ctl_pwr_on;
            off_q <= ctl_disp_off;
        end
    end

    lcd_scan_fsm #(.SLOT_CYCLES(SLOT_CYCLES)) u_scan (
        .clk      (clk),
        .rst_n    (rst_n),
        .duty     (duty_sel),
        .slot_sel (slot_sel),
        .neg_pol  (neg_pol)
    );

    lcd_disp_mem #(.DEPTH(MEM_DEPTH), .N_SEG(N_SEG), .NW(N_COM)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .nib   (nib)
    );

    lcd_level_map #(.N_SEG(N_SEG)) u_map (
        .slot_sel    (slot_sel),
        .neg_pol     (neg_pol),
        .pwr_on      (pwr_q),
        .disp_off    (off_q),
        .static_mask (static_mask),
        .nib         (nib),
        .com_lvl     (com_lvl),
        .seg_lvl     (seg_lvl)
    );

endmodule

// File: rtl/lcd_mux_drive_chk.sv
module lcd_mux_drive_chk
    import lcd_drv_pkg::*;
#(
    parameter int SLOT_CYCLES = 256,
    parameter int N_SEG       = 22
) (
    input logic               clk,
    input logic               rst_n,
    input logic [1:0]         duty,
    input logic [N_SEG-1:0]   static_mask,
    input logic               pwr,
    input logic               off,
    input logic [2*N_COM-1:0] com_lvl,
    input logic [2*N_SEG-1:0] seg_lvl
);

    localparam int CW = $clog2(SLOT_CYCLES);

    logic [CW-1:0]    cyc;
    logic [N_COM-1:0] ext;
    logic [1:0]       sel_code;
    logic             unsel_ok, pwroff_ok, blank_ok, static_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cyc <= '0;
        else        cyc <= (cyc == CW'(SLOT_CYCLES - 1)) ? '0 : cyc + 1'b1;
    end

    always_comb begin
        sel_code  = 2'd0;
        unsel_ok  = 1'b1;
        pwroff_ok = 1'b1;
        blank_ok  = 1'b1;
        static_ok = 1'b1;
        for (int k = 0; k < N_COM; k++) begin
            ext[k] = (com_lvl[2*k +: 2] == 2'd0) || (com_lvl[2*k +: 2] == 2'd3);
            if (ext[k]) sel_code = com_lvl[2*k +: 2];
            if (com_lvl[2*k +: 2] != 2'd2) pwroff_ok = 1'b0;
        end
        for (int k = 0; k < N_COM; k++) begin
            if (!ext[k] && com_lvl[2*k +: 2] != ((sel_code == 2'd3) ? 2'd1 : 2'd2))
                unsel_ok = 1'b0;
        end
        for (int n = 0; n < N_SEG; n++) begin
            if (static_mask[n]) begin
                if (seg_lvl[2*n +: 2] != 2'd0 && seg_lvl[2*n +: 2] != 2'd3) static_ok = 1'b0;
            end else begin
                if (seg_lvl[2*n +: 2] != 2'd2) pwroff_ok = 1'b0;
                if (seg_lvl[2*n +: 2] != ((sel_code == 2'd3) ? 2'd2 : 2'd1)) blank_ok = 1'b0;
            end
        end
    end

    assert_one_com_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pwr |-> $countones(ext) == 1);

    assert_slot_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr && $past(pwr) && ext != $past(ext)) |-> cyc == '0);

    assert_unused_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr && duty == 2'd0) |-> (!ext[2] && !ext[3]));

    assert_unused_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr && duty == 2'd1) |-> !ext[3]);

    assert_unsel_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pwr |-> unsel_ok);

    assert_pwr_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr |-> pwroff_ok);

    assert_blank_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr && off) |-> blank_ok);

    assert_static_dc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        static_ok);

endmodule

bind lcd_mux_drive lcd_mux_drive_chk #(
    .SLOT_CYCLES (SLOT_CYCLES),
    .N_SEG       (N_SEG)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .duty        (duty_sel),
    .static_mask (static_mask),
    .pwr         (pwr_q),
    .off         (off_q),
    .com_lvl     (com_lvl),
    .seg_lvl     (seg_lvl)
);

// File: tb/tb_lcd_mux_drive.sv
module tb_lcd_mux_drive;

    localparam int CLK_PERIOD = 10;
    localparam int NSEG = 22;
    localparam int NCOM = 4;
    localparam int SLOT = 256;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       duty_sel = 2'd0;
    logic [NSEG-1:0]  static_mask = '0;
    logic             mem_we = 1'b0;
    logic [4:0]       mem_addr = '0;
    logic [3:0]       mem_wdata = '0;
    logic             ctl_we = 1'b0;
    logic             ctl_pwr_on = 1'b0;
    logic             ctl_disp_off = 1'b0;
    logic [2*NCOM-1:0] com_lvl;
    logic [2*NSEG-1:0] seg_lvl;

    int checks = 0;
    int failures = 0;
    string tag = "R6";

    // behavioural model state
    int t;
    int m_mem[32];
    bit m_pwr, m_off;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcd_mux_drive dut (
        .clk(clk), .rst_n(rst_n), .duty_sel(duty_sel), .static_mask(static_mask),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .ctl_we(ctl_we), .ctl_pwr_on(ctl_pwr_on), .ctl_disp_off(ctl_disp_off),
        .com_lvl(com_lvl), .seg_lvl(seg_lvl)
    );

    function automatic int frame_len();
        return (duty_sel == 2'd1) ? 3 * SLOT : 4 * SLOT;
    endfunction

    function automatic int n_used();
        if (duty_sel == 2'd0) return 2;
        if (duty_sel == 2'd1) return 3;
        return 4;
    endfunction

    task automatic compare();
        logic [2*NCOM-1:0] e_com;
        logic [2*NSEG-1:0] e_seg;
        int ph = t % frame_len();
        int act = (t / SLOT) % n_used();
        bit neg = (ph >= frame_len() / 2);
        for (int k = 0; k < NCOM; k++) begin
            int v;
            if (!m_pwr)         v = 2;
            else if (k == act)  v = neg ? 0 : 3;
            else                v = neg ? 2 : 1;
            e_com[2*k +: 2] = 2'(v);
        end
        for (int n = 0; n < NSEG; n++) begin
            int v;
            bit lit = ((m_mem[n] >> act) & 1) == 1;
            if (static_mask[n])     v = (m_mem[n] & 1) ? 3 : 0;
            else if (!m_pwr)        v = 2;
            else if (lit && !m_off) v = neg ? 3 : 0;
            else                    v = neg ? 1 : 2;
            e_seg[2*n +: 2] = 2'(v);
        end
        checks++;
        if (com_lvl !== e_com || seg_lvl !== e_seg) begin
            failures++;
            $display("FAIL %s duty=%0d t=%0d com act=%h exp=%h seg act=%h exp=%h",
                     tag, duty_sel, t, com_lvl, e_com, seg_lvl, e_seg);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        t++;
        if (mem_we) m_mem[mem_addr] = int'(mem_wdata);
        if (ctl_we) begin
            m_pwr = ctl_pwr_on;
            m_off = ctl_disp_off;
        end
        @(negedge clk);
        compare();
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic do_reset(input logic [1:0] d, input logic [NSEG-1:0] smask);
        rst_n = 1'b0;
        duty_sel = d;
        static_mask = smask;
        mem_we = 1'b0;
        ctl_we = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t = 0;
        for (int a = 0; a < 32; a++) m_mem[a] = 0;
        m_pwr = 1'b0;
        m_off = 1'b0;
        tag = "R6";
        compare();   // reset state: power off, display on
    endtask

    task automatic write_nib(input int a, input int v);
        mem_we = 1'b1;
        mem_addr = 5'(a);
        mem_wdata = 4'(v);
        tick();
        mem_we = 1'b0;
    endtask

    task automatic write_ctl(input bit p, input bit o);
        ctl_we = 1'b1;
        ctl_pwr_on = p;
        ctl_disp_off = o;
        tick();
        ctl_we = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int d = 0; d < 4; d++) begin
            logic [NSEG-1:0] sm = (d == 2) ? 22'h200009 : '0;
            do_reset(2'(d), sm);
            // R6: power-off default holds all terminals at VC2
            run(20);
            // R5: segment data, bit k of nibble n at common k
            tag = "R5";
            for (int n = 0; n < NSEG; n++) write_nib(n, (n * 7 + d * 3 + 1) & 15);
            // R1 and R4: scanning waveform with power on
            tag = "R1";
            write_ctl(1'b1, 1'b0);
            run(frame_len() - 40);
            // R3: second frame covers the polarity flips at the half-frame points
            tag = "R3";
            run(frame_len() + 17);
            // R5: rewrite mid-scan
            tag = "R5";
            write_nib(3, 4'hF);
            write_nib(4, 4'h0);
            run(SLOT + 5);
            // R7: display off blanks segments, commons keep scanning
            tag = "R7";
            write_ctl(1'b1, 1'b1);
            run(300);
            write_ctl(1'b1, 1'b0);
            run(20);
            // R9: writes beyond the last segment change nothing
            tag = "R9";
            write_nib(25, 4'hF);
            write_nib(31, 4'hA);
            run(60);
            // R8: static pins ignore power and display-off
            tag = "R8";
            write_nib(0, 4'h1);
            write_nib(21, 4'h0);
            write_ctl(1'b0, 1'b1);
            run(40);
            write_nib(21, 4'hF);
            run(10);
            // R2: unused commons in this duty code stay unselected
            tag = "R2";
            write_ctl(1'b1, 1'b0);
            run(4 * SLOT);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule